// File: doc/BRIEF.md
# SPI Register-Access Master

This block runs one read or write transaction at a time against a remote configuration device over a 4-wire, mode-0 SPI link. The user presents a 4-bit target number, a write flag and up to 32 bits of write data, then pulses `start`. The block looks up the length of the data field from the target range. It shifts out a 7-bit address, a write-enable bit and the data field, all most significant bit first. During the data phase it collects the bits that come back on MISO. When chip select releases, it presents the returned bits right-aligned on `rdata` together with a one-cycle `done` pulse.

SCK is derived from the system clock by a programmable half-period count, so the SCK period is at least two system clocks. A controller state machine sequences each frame through these states:
- `ST_IDLE`: chip select high, SCK low. `start` moves the machine to `ST_SETUP`.
- `ST_SETUP`: chip select low for one half period. A half-period tick moves it to `ST_SCK_HI`.
- `ST_SCK_HI` and `ST_SCK_LO`: alternating half periods. A tick in `ST_SCK_HI` moves to `ST_SCK_LO`, or to `ST_HOLD` after the last falling edge. A tick in `ST_SCK_LO` moves to `ST_SCK_HI`.
- `ST_HOLD`: one half period with SCK low and chip select still low. A tick moves it to `ST_GAP` and fires `done`.
- `ST_GAP`: chip select high for two half periods. After the second tick the machine returns to `ST_IDLE`.

Top module: `spi_regmaster`

## Requirements
- R1: After reset, `cs_n` is 1, `sck` is 0, `busy` is 0, `done` is 0 and `rdata` is 0.
- R2: The data field length comes from `tgt_addr[3:2]`: 00 gives 16 bits, 01 gives 32 bits, 10 gives 8 bits and 11 gives 8 bits. A frame has exactly 8 plus that length SCK rising edges.
- R3: A frame carries, MSB first, the 7-bit address (upper three bits zero, lower four bits `tgt_addr`), then the write-enable bit (1 for write, equal to `wr_en`), then the low data-length bits of `wdata`. MOSI changes only while SCK is low and is stable for the whole high phase.
- R4: SCK idles low and pulses only while `cs_n` is low. Each high phase lasts `half_div` system clocks, and a `half_div` of 0 acts as 1.
- R5: `cs_n` falls at least one half period before the first SCK rise. It rises at least one half period after the last SCK fall. It stays high for at least two half periods between consecutive frames.
- R6: MISO is sampled on SCK rising edges of the data phase only, and those bits are placed right-aligned in `rdata` with the unused upper bits zero. The remote device starts driving data on the falling edge that follows the write-enable bit.
- R7: `done` is a single-cycle pulse issued in the cycle `cs_n` rises, while `busy` is still 1. `busy` stays 1 from the accepted start until the inter-frame gap ends.
- R8: A `start` pulse while `busy` is 1 is ignored: no further frame is sent, and the frame in progress keeps its address and timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a transaction (accepted only when idle) |
| tgt_addr | input | 4 | Target number; bits [3:2] pick the data length |
| wr_en | input | 1 | Write-enable bit placed in the frame |
| wdata | input | 32 | Write data, low bits used |
| half_div | input | DIV_W | SCK half period in system clocks (0 acts as 1) |
| miso | input | 1 | Serial data from the remote device |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Returned data, right-aligned |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the remote device |
| cs_n | output | 1 | Active-low chip select |

## Verification
The hardest case to reach from the ports is a second `start` that arrives mid-frame. That pulse must leave the ongoing frame, and the frame count seen by the remote end, untouched. The bench issues it several cycles after the first request, while SCK is already toggling, and then counts frames at a model of the remote shift register. The remote model drives ones on MISO during the header, so any header bit wrongly sampled into `rdata` shows up for the short 8-bit targets. Back-to-back requests issued the moment `busy` drops are what expose the chip-select gap.

// File: rtl/spi_rm_pkg.sv
package spi_rm_pkg;
    localparam int TGT_W    = 4;
    localparam int ADDR_W   = 7;
    localparam int DATA_MAX = 32;
    localparam int HDR_W    = ADDR_W + 1;
    localparam int FRAME_W  = HDR_W + DATA_MAX;
    localparam int LEN_W    = $clog2(DATA_MAX + 1);
    localparam int CNT_W    = $clog2(FRAME_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SCK_HI,
        ST_SCK_LO,
        ST_HOLD,
        ST_GAP
    } rm_state_e;
endpackage

// File: rtl/spi_rm_clkgen.sv
module spi_rm_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim;

    // a zero half period is clamped to one system clock
    assign lim  = (half == '0) ? '0 : half - DIV_W'(1);
    assign tick = en && (cnt_q == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/spi_rm_lenlut.sv
module spi_rm_lenlut
    import spi_rm_pkg::*;
#(
    parameter int LEN_REG = 16,
    parameter int LEN_PLL = 32,
    parameter int LEN_ATT = 8,
    parameter int LEN_MEZ = 8
) (
    input  logic [1:0]       cls,
    output logic [LEN_W-1:0] dlen
);
    always_comb begin
        unique case (cls)
            2'b00:   dlen = LEN_W'(LEN_REG);
            2'b01:   dlen = LEN_W'(LEN_PLL);
            2'b10:   dlen = LEN_W'(LEN_ATT);
            default: dlen = LEN_W'(LEN_MEZ);
        endcase
    end

    always_comb begin
        a_r2_len_legal: assert (dlen == LEN_W'(LEN_REG) || dlen == LEN_W'(LEN_PLL) ||
                                dlen == LEN_W'(LEN_ATT) || dlen == LEN_W'(LEN_MEZ));
    end
endmodule

// File: rtl/spi_rm_shreg.sv
module spi_rm_shreg
    import spi_rm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [FRAME_W-1:0]  frame,
    input  logic                shift,
    input  logic                cap,
    input  logic                miso,
    output logic                mosi,
    output logic [DATA_MAX-1:0] rdata
);
    logic [FRAME_W-1:0]  tx_q;
    logic [DATA_MAX-1:0] rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= frame;
        end else if (shift) begin
            tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (load) begin
            rx_q <= '0;
        end else if (cap) begin
            rx_q <= {rx_q[DATA_MAX-2:0], miso};
        end
    end

    assign mosi  = tx_q[FRAME_W-1];
    assign rdata = rx_q;

    // R6: capture never coincides with a new load or with a shift
    a_r6_cap_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        cap |-> !load && !shift);
endmodule

// File: rtl/spi_regmaster.sv
module spi_regmaster
    import spi_rm_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [TGT_W-1:0]    tgt_addr,
    input  logic                wr_en,
    input  logic [DATA_MAX-1:0] wdata,
    input  logic [DIV_W-1:0]    half_div,
    input  logic                miso,
    output logic                busy,
    output logic                done,
    output logic [DATA_MAX-1:0] rdata,
    output logic                sck,
    output logic                mosi,
    output logic                cs_n
);
    rm_state_e           state_q, state_d;
    logic                tick;
    logic [LEN_W-1:0]    dlen_w;
    logic [DATA_MAX-1:0] data_al;
    logic [FRAME_W-1:0]  frame_w;
    logic                load, rise_ev, fall_ev, last_fall, cap;
    logic [CNT_W-1:0]    nbits_q, bcnt_q;
    logic [DIV_W-1:0]    half_q;
    logic                gap_q;
    logic                sck_q, cs_n_q, done_q;

    spi_rm_lenlut u_len (
        .cls  (tgt_addr[TGT_W-1 -: 2]),
        .dlen (dlen_w)
    );

    // left-align the used data bits so they leave MSB first
    assign data_al = wdata << (LEN_W'(DATA_MAX) - dlen_w);
    assign frame_w = {{(ADDR_W-TGT_W){1'b0}}, tgt_addr, wr_en, data_al};

    spi_rm_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state_q != ST_IDLE),
        .half  (half_q),
        .tick  (tick)
    );

    assign load      = (state_q == ST_IDLE) && start;
    assign rise_ev   = tick && (state_q == ST_SETUP || state_q == ST_SCK_LO);
    assign fall_ev   = tick && (state_q == ST_SCK_HI);
    assign last_fall = fall_ev && (bcnt_q + CNT_W'(1) == nbits_q);
    assign cap       = rise_ev && (bcnt_q >= CNT_W'(HDR_W));

    spi_rm_shreg u_sr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .frame (frame_w),
        .shift (fall_ev),
        .cap   (cap),
        .miso  (miso),
        .mosi  (mosi),
        .rdata (rdata)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_SETUP;
            ST_SETUP:  if (tick) state_d = ST_SCK_HI;
            ST_SCK_HI: if (tick) state_d = last_fall ? ST_HOLD : ST_SCK_LO;
            ST_SCK_LO: if (tick) state_d = ST_SCK_HI;
            ST_HOLD:   if (tick) state_d = ST_GAP;
            ST_GAP:    if (tick && gap_q) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // frame bookkeeping registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nbits_q <= '0;
            half_q  <= '0;
            bcnt_q  <= '0;
            gap_q   <= 1'b0;
        end else begin
            if (load) begin
                nbits_q <= CNT_W'(HDR_W) + CNT_W'(dlen_w);
                half_q  <= half_div;
                bcnt_q  <= '0;
            end else if (fall_ev) begin
                bcnt_q <= bcnt_q + CNT_W'(1);
            end
            if (state_q != ST_GAP) gap_q <= 1'b0;
            else if (tick)         gap_q <= 1'b1;
        end
    end

    // registered pin outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q  <= 1'b0;
            cs_n_q <= 1'b1;
            done_q <= 1'b0;
        end else begin
            sck_q  <= (state_d == ST_SCK_HI);
            cs_n_q <= (state_d == ST_IDLE) || (state_d == ST_GAP);
            done_q <= (state_q == ST_HOLD) && (state_d == ST_GAP);
        end
    end

    assign sck  = sck_q;
    assign cs_n = cs_n_q;
    assign done = done_q;
    assign busy = (state_q != ST_IDLE);

    // R4: no clock pulse outside chip select
    a_r4_sck_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_q |-> !sck_q);
    // R3: data line held through each high phase
    a_r3_mosi_stable_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_q && $past(sck_q)) |-> $stable(mosi));
    // R7: completion pulse is one cycle wide
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R7: completion coincides with chip-select release while still busy
    a_r7_done_cs: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> cs_n_q && busy);
    // R8: a request while busy changes nothing latched for the frame
    a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(nbits_q) && $stable(half_q));
    // R2: falling-edge count never runs past the frame length
    a_r2_bcnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bcnt_q <= nbits_q);
endmodule

// File: tb/spi_regmaster_tb.sv
module spi_regmaster_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  tgt_addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [7:0]  half_div = 8'd1;
    logic        miso = 1'b1;
    logic        busy, done, sck, mosi, cs_n;
    logic [31:0] rdata;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    spi_regmaster #(.DIV_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .tgt_addr(tgt_addr),
        .wr_en(wr_en), .wdata(wdata), .half_div(half_div), .miso(miso),
        .busy(busy), .done(done), .rdata(rdata), .sck(sck), .mosi(mosi),
        .cs_n(cs_n)
    );

    function automatic int len_of(input logic [3:0] a);
        case (a[3:2])
            2'b00:   return 16;
            2'b01:   return 32;
            default: return 8;
        endcase
    endfunction

    function automatic logic [31:0] mask_of(input int n);
        if (n >= 32) return 32'hFFFF_FFFF;
        if (n <= 0) return 32'h0;
        return (32'h1 << n) - 32'h1;
    endfunction

    function automatic logic [31:0] resp_of(input logic [6:0] a);
        return 32'hC3A5_5A3C ^ {4{1'b0, a}};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // remote shift-register model, sampled away from the active edge
    logic        p_sck = 1'b0, p_cs = 1'b1, p_done = 1'b0, p_mosi = 1'b0;
    logic [63:0] shin;
    int rises, falls, m_dlen, setup_cnt, hold_cnt, hi_run, hi_min, hi_max;
    int gap_cnt, rec_gap, frames, rec_rises, rec_setup, rec_hold;
    int rec_himin, rec_himax, mosi_viol, done_viol;
    bit seen_rise;
    logic [6:0]  m_addr, rec_addr;
    logic        rec_we;
    logic [31:0] rec_data;
    logic [63:0] hdr;

    always @(negedge clk) begin
        if (!rst_n) begin
            shin = '0; rises = 0; falls = 0; m_dlen = 0; setup_cnt = 0;
            hold_cnt = 0; hi_run = 0; hi_min = 9999; hi_max = 0; gap_cnt = 0;
            rec_gap = 0; frames = 0; rec_rises = 0; rec_setup = 0; rec_hold = 0;
            rec_himin = 0; rec_himax = 0; mosi_viol = 0; done_viol = 0;
            seen_rise = 0; m_addr = '0; rec_addr = '0; rec_we = 0; rec_data = '0;
            miso = 1'b1;
        end else begin
            if (p_cs && !cs_n) begin
                rises = 0; falls = 0; shin = '0; setup_cnt = 0; seen_rise = 0;
                hi_min = 9999; hi_max = 0; hi_run = 0; hold_cnt = 0;
                rec_gap = gap_cnt; miso = 1'b1;
            end
            if (!cs_n) begin
                if (sck && !p_sck) begin
                    rises++; shin = {shin[62:0], mosi}; seen_rise = 1; hi_run = 0;
                end
                if (!sck && p_sck) begin
                    falls++;
                    if (hi_run < hi_min) hi_min = hi_run;
                    if (hi_run > hi_max) hi_max = hi_run;
                    hi_run = 0; hold_cnt = 0;
                    if (falls == 8) begin
                        m_addr = shin[7:1];
                        m_dlen = len_of(m_addr[3:0]);
                    end
                    if (falls >= 8 && (falls - 8) < m_dlen)
                        miso = resp_of(m_addr)[m_dlen - 1 - (falls - 8)];
                    else
                        miso = 1'b1;
                end
                if (sck) hi_run++;
                else if (seen_rise) hold_cnt++;
                if (!seen_rise) setup_cnt++;
                if (sck && p_sck && mosi != p_mosi) mosi_viol++;
            end
            if (!p_cs && cs_n) begin
                frames++;
                rec_rises = rises; rec_setup = setup_cnt; rec_hold = hold_cnt;
                rec_himin = hi_min; rec_himax = hi_max;
                if (rises >= 8) begin
                    hdr = shin >> (rises - 8);
                    rec_addr = hdr[7:1];
                    rec_we = hdr[0];
                    rec_data = shin[31:0] & mask_of(rises - 8);
                end
                gap_cnt = 0;
            end
            if (cs_n) gap_cnt++;
            if (done && p_done) done_viol++;
            p_sck = sck; p_cs = cs_n; p_done = done; p_mosi = mosi;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wait_done(output bit ok);
        int to = 0;
        while (!done && to < 20000) begin
            @(negedge clk);
            to++;
        end
        ok = done;
    endtask

    task automatic xfer(input logic [3:0] a, input logic w, input logic [31:0] wd,
                        input int half);
        int eh = (half == 0) ? 1 : half;
        int dl = len_of(a);
        int f0 = frames;
        bit ok;
        @(negedge clk);
        tgt_addr = a; wr_en = w; wdata = wd; half_div = 8'(half); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(ok);
        chk(ok, "R7 done seen", 64'(ok), 1);
        chk(busy && cs_n, "R7 busy and cs_n at done", {busy, cs_n}, 2'b11);
        @(negedge clk);
        chk(frames == f0 + 1, "R2 frame count", frames, f0 + 1);
        chk(rec_rises == 8 + dl, "R2 sck rises", rec_rises, 8 + dl);
        chk(rec_addr == {3'b000, a}, "R3 address", rec_addr, {3'b000, a});
        chk(rec_we == w, "R3 we bit", rec_we, w);
        if (w) chk(rec_data == (wd & mask_of(dl)), "R3 write data", rec_data,
                   wd & mask_of(dl));
        chk(rdata == (resp_of({3'b000, a}) & mask_of(dl)), "R6 read data", rdata,
            resp_of({3'b000, a}) & mask_of(dl));
        chk(rec_setup >= eh, "R5 cs setup", rec_setup, eh);
        chk(rec_hold >= eh, "R5 cs hold", rec_hold, eh);
        chk(rec_himin == eh && rec_himax == eh, "R4 sck high time",
            {32'(rec_himin), 32'(rec_himax)}, {32'(eh), 32'(eh)});
        chk(mosi_viol == 0, "R3 mosi stable while sck high", mosi_viol, 0);
        chk(done_viol == 0, "R7 done single cycle", done_viol, 0);
        while (busy) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
        chk(sck == 1'b0, "R1 sck", sck, 0);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(rdata == 32'h0, "R1 rdata", rdata, 0);
    endtask

    task automatic t_writes();
        xfer(4'h2, 1'b1, 32'hDEAD_BEEF, 1);
        xfer(4'h5, 1'b1, 32'h8123_4567, 1);
        xfer(4'h9, 1'b1, 32'h0000_01A7, 2);
        xfer(4'hE, 1'b1, 32'hFFFF_FF3C, 2);
    endtask

    task automatic t_reads();
        xfer(4'h0, 1'b0, 32'h0, 3);
        xfer(4'h7, 1'b0, 32'h0, 3);
        xfer(4'hB, 1'b0, 32'h0, 4);
        xfer(4'hC, 1'b0, 32'h0, 4);
    endtask

    task automatic t_div_zero();
        xfer(4'h3, 1'b1, 32'h0000_5A5A, 0);
    endtask

    task automatic t_gap();
        xfer(4'h1, 1'b1, 32'h1234, 2);
        xfer(4'h6, 1'b0, 32'h0, 2);
        chk(rec_gap >= 4, "R5 cs high gap", rec_gap, 4);
    endtask

    task automatic t_busy_ignore();
        int f0 = frames;
        bit ok;
        @(negedge clk);
        tgt_addr = 4'h8; wr_en = 1'b1; wdata = 32'h77; half_div = 8'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (9) @(negedge clk);
        tgt_addr = 4'h4; wr_en = 1'b0; half_div = 8'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(ok);
        while (busy) @(negedge clk);
        repeat (30) @(negedge clk);
        chk(frames == f0 + 1, "R8 single frame", frames, f0 + 1);
        chk(rec_addr == 7'h08, "R8 first address kept", rec_addr, 7'h08);
        chk(rec_rises == 16, "R8 first length kept", rec_rises, 16);
        chk(busy == 1'b0 && cs_n == 1'b1, "R8 idle after", {busy, cs_n}, 2'b01);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_writes();
        t_reads();
        t_div_zero();
        t_gap();
        t_busy_ignore();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule